// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block predicts which earlier store an out-of-order core's load or store should wait for. It keeps three structures. An instruction table is indexed by program counter and maps each instruction to a set number, with a valid flag on every slot. A per-set register holds the sequence number of the youngest fetched store of that set, with its own valid flag. A per-set size counter records how many stores belong to the set.

The core sends the block at most one request per cycle on `req_op`. A violation report trains the sets. A store fetch records the youngest store of its set. A store issue retires that record. A squash drops records older than a given sequence number. Clear forgets everything learned. A separate lookup port answers combinationally with the sequence number the instruction must wait for, or zero when it has no dependence. Every table update becomes visible after the next rising clock edge.

Top module: `store_set_predictor`

## Requirements
- R1: The instruction-table slot is `(pc >> 2) & (SSIT_DEPTH-1)`. PCs that differ only in bits 1:0, or that are a multiple of `4*SSIT_DEPTH` apart, share a slot. `lk_seq` is 0 while the lookup slot is not valid.
- R2: On a violation (`req_op`=1, store PC on `req_pc`, load PC on `req_load_pc`) where neither slot is valid, both slots get set number `(load_pc >> 2) & (LFST_DEPTH-1)` and become valid. That set's size counter increments.
- R3: On a violation where only the load slot is valid, the store slot takes the load's set and becomes valid. That set's counter increments.
- R4: On a violation where only the store slot is valid, the load slot takes the store's set and becomes valid. No counter changes.
- R5: On a violation where both slots are valid and the load set's counter is strictly greater than the store set's, the store slot moves to the load's set. The load set's counter increments and the store set's counter decrements.
- R6: On any other violation with both slots valid, ties included, the load slot moves to the store's set. The store set's counter increments and the load set's counter decrements. Counters saturate at 0 and at their maximum. When both slots are already in the same set, that counter is unchanged.
- R7: A store fetch (`req_op`=2) whose slot is valid writes `req_seq` into its set's youngest-store register and marks it valid. With an invalid slot the fetch has no effect.
- R8: A store issue (`req_op`=3) with `req_is_store`=1 and a valid slot clears the set's youngest-store register only when that register is valid and equal to `req_seq`. An issue with `req_is_store`=0 has no effect.
- R9: A squash (`req_op`=4) clears every valid youngest-store register whose sequence number is unsigned-less than `req_seq`. Equal numbers survive.
- R10: Clear (`req_op`=5) drops every instruction-table and youngest-store valid flag. Reset does the same and also zeroes the size counters.
- R11: When the lookup slot and its set's youngest-store register are both valid, `lk_seq` is that register's sequence number, otherwise 0. An update made by a request is visible after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_op | input | 3 | Request: 0 none, 1 violation, 2 store fetch, 3 issue, 4 squash, 5 clear |
| req_pc | input | PC_W | Store PC (violation, fetch, issue) |
| req_load_pc | input | PC_W | Load PC of a violation |
| req_seq | input | SEQ_W | Sequence number for fetch, issue or squash |
| req_is_store | input | 1 | Issue request concerns a store |
| lk_pc | input | PC_W | PC to look up |
| lk_seq | output | SEQ_W | Sequence number to wait for, 0 when none |

## Verification
The hardest behaviour to reach is the set-merge choice. It depends on size counters that never reach a port, so the two merge directions and the tie rule can only be seen through lookups of the other instructions in the sets. The stimulus first grows one set to size two and creates a second set of size one, then reports a violation between them. It also builds two sets of equal size and merges them. After each merge it fetches a store and looks up a load whose answer differs depending on which instruction moved. A later merge against a set whose counter has already dropped to zero exercises the saturating decrement.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_VIOL   = 3'd1,
    OP_FETCH  = 3'd2,
    OP_ISSUE  = 3'd3,
    OP_SQUASH = 3'd4,
    OP_CLEAR  = 3'd5
  } op_e;

  localparam int unsigned PC_DROP = 2;

  // Slot/set selection: drop the byte offset, keep log2(depth) bits.
  function automatic logic [63:0] slot_of(input logic [63:0] pc, input int unsigned depth);
    return (pc >> PC_DROP) & (64'(depth) - 64'd1);
  endfunction

  // Merge direction: the store moves only when the load's set is strictly bigger.
  function automatic logic load_set_wins(input logic [31:0] ld_cnt, input logic [31:0] st_cnt);
    return ld_cnt > st_cnt;
  endfunction
endpackage

// File: rtl/ssp_id_table.sv
`timescale 1ns/1ps
module ssp_id_table #(
  parameter int DEPTH = 64,
  parameter int IX_W  = 6,
  parameter int ID_W  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [IX_W-1:0] rd_st_ix,
  input  logic [IX_W-1:0] rd_ld_ix,
  input  logic [IX_W-1:0] rd_lk_ix,
  output logic            st_hit,
  output logic [ID_W-1:0] st_id,
  output logic            ld_hit,
  output logic [ID_W-1:0] ld_id,
  output logic            lk_hit,
  output logic [ID_W-1:0] lk_id,
  input  logic            wr_st_en,
  input  logic [ID_W-1:0] wr_st_id,
  input  logic            wr_ld_en,
  input  logic [ID_W-1:0] wr_ld_id
);
  logic [DEPTH-1:0] vld_q;
  logic [ID_W-1:0]  id_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit_st, hit_ld;
    assign hit_st = wr_st_en && (rd_st_ix == IX_W'(g));
    assign hit_ld = wr_ld_en && (rd_ld_ix == IX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        id_q[g]  <= '0;
      end else if (clr) begin
        vld_q[g] <= 1'b0;
      end else if (hit_st) begin
        vld_q[g] <= 1'b1;
        id_q[g]  <= wr_st_id;
      end else if (hit_ld) begin
        vld_q[g] <= 1'b1;
        id_q[g]  <= wr_ld_id;
      end
    end
  end

  assign st_hit = vld_q[rd_st_ix];
  assign st_id  = id_q[rd_st_ix];
  assign ld_hit = vld_q[rd_ld_ix];
  assign ld_id  = id_q[rd_ld_ix];
  assign lk_hit = vld_q[rd_lk_ix];
  assign lk_id  = id_q[rd_lk_ix];
endmodule

// File: rtl/ssp_last_store.sv
`timescale 1ns/1ps
module ssp_last_store #(
  parameter int DEPTH = 16,
  parameter int ID_W  = 4,
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [ID_W-1:0]  wr_id,
  input  logic [SEQ_W-1:0] wr_seq,
  input  logic             iss_en,
  input  logic [ID_W-1:0]  iss_id,
  input  logic [SEQ_W-1:0] iss_seq,
  input  logic             sq_en,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic [ID_W-1:0]  rd_id,
  output logic             rd_valid,
  output logic [SEQ_W-1:0] rd_seq,
  output logic [DEPTH-1:0] valid_vec
);
  logic [SEQ_W-1:0] seq_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_set
    logic do_wr, do_iss, do_sq;
    assign do_wr  = wr_en && (wr_id == ID_W'(g));
    assign do_iss = iss_en && (iss_id == ID_W'(g)) && valid_vec[g] && (seq_q[g] == iss_seq);
    assign do_sq  = sq_en && valid_vec[g] && (seq_q[g] < sq_seq);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_vec[g] <= 1'b0;
        seq_q[g]     <= '0;
      end else if (clr || do_iss || do_sq) begin
        valid_vec[g] <= 1'b0;
      end else if (do_wr) begin
        valid_vec[g] <= 1'b1;
        seq_q[g]     <= wr_seq;
      end
    end
  end

  assign rd_valid = valid_vec[rd_id];
  assign rd_seq   = seq_q[rd_id];
endmodule

// File: rtl/ssp_set_size.sv
`timescale 1ns/1ps
module ssp_set_size #(
  parameter int DEPTH = 16,
  parameter int ID_W  = 4,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic [ID_W-1:0]  inc_id,
  input  logic             dec_en,
  input  logic [ID_W-1:0]  dec_id,
  input  logic [ID_W-1:0]  rd_a_id,
  input  logic [ID_W-1:0]  rd_b_id,
  output logic [CNT_W-1:0] cnt_a,
  output logic [CNT_W-1:0] cnt_b
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ctr
    logic up, dn;
    assign up = inc_en && (inc_id == ID_W'(g));
    assign dn = dec_en && (dec_id == ID_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[g] <= '0;
      end else if (up && !dn && cnt_q[g] != CNT_MAX) begin
        cnt_q[g] <= cnt_q[g] + 1'b1;
      end else if (dn && !up && cnt_q[g] != '0) begin
        cnt_q[g] <= cnt_q[g] - 1'b1;
      end
    end
  end

  assign cnt_a = cnt_q[rd_a_id];
  assign cnt_b = cnt_q[rd_b_id];
endmodule

// File: rtl/store_set_predictor.sv
`timescale 1ns/1ps
module store_set_predictor #(
  parameter int PC_W       = 32,
  parameter int SEQ_W      = 16,
  parameter int SSIT_DEPTH = 64,
  parameter int LFST_DEPTH = 16,
  parameter int CNT_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       req_op,
  input  logic [PC_W-1:0]  req_pc,
  input  logic [PC_W-1:0]  req_load_pc,
  input  logic [SEQ_W-1:0] req_seq,
  input  logic             req_is_store,
  input  logic [PC_W-1:0]  lk_pc,
  output logic [SEQ_W-1:0] lk_seq
);
  import ssp_pkg::*;
  localparam int IX_W = $clog2(SSIT_DEPTH);
  localparam int ID_W = $clog2(LFST_DEPTH);

  op_e op;
  assign op = op_e'(req_op);

  logic [IX_W-1:0] st_ix, ld_ix, lk_ix;
  logic [ID_W-1:0] new_id;
  assign st_ix  = IX_W'(slot_of(64'(req_pc), SSIT_DEPTH));
  assign ld_ix  = IX_W'(slot_of(64'(req_load_pc), SSIT_DEPTH));
  assign lk_ix  = IX_W'(slot_of(64'(lk_pc), SSIT_DEPTH));
  assign new_id = ID_W'(slot_of(64'(req_load_pc), LFST_DEPTH));

  logic            st_hit, ld_hit, lk_hit;
  logic [ID_W-1:0] st_ssid, ld_ssid, lk_ssid;
  logic [CNT_W-1:0] cnt_st, cnt_ld;

  // Named violation events (one-hot by construction of the case split).
  logic is_viol, both_hit;
  logic ev_new_set, ev_store_joins, ev_load_joins, ev_store_moves, ev_load_moves;
  assign is_viol        = (op == OP_VIOL);
  assign both_hit       = is_viol && st_hit && ld_hit;
  assign ev_new_set     = is_viol && !st_hit && !ld_hit;
  assign ev_store_joins = is_viol && ld_hit && !st_hit;
  assign ev_load_joins  = is_viol && st_hit && !ld_hit;
  assign ev_store_moves = both_hit && load_set_wins(32'(cnt_ld), 32'(cnt_st));
  assign ev_load_moves  = both_hit && !load_set_wins(32'(cnt_ld), 32'(cnt_st));

  logic            wr_st_en, wr_ld_en, inc_en, dec_en;
  logic [ID_W-1:0] wr_st_id, wr_ld_id, inc_id, dec_id;
  assign wr_st_en = ev_new_set || ev_store_joins || ev_store_moves;
  assign wr_st_id = ev_new_set ? new_id : ld_ssid;
  assign wr_ld_en = ev_new_set || ev_load_joins || ev_load_moves;
  assign wr_ld_id = ev_new_set ? new_id : st_ssid;
  assign inc_en   = ev_new_set || ev_store_joins || ev_store_moves || ev_load_moves;
  assign inc_id   = ev_new_set ? new_id : (ev_load_moves ? st_ssid : ld_ssid);
  assign dec_en   = ev_store_moves || ev_load_moves;
  assign dec_id   = ev_store_moves ? st_ssid : ld_ssid;

  logic tbl_clr, lf_wr, lf_iss, lf_sq;
  assign tbl_clr = (op == OP_CLEAR);
  assign lf_wr   = (op == OP_FETCH) && st_hit;
  assign lf_iss  = (op == OP_ISSUE) && req_is_store && st_hit;
  assign lf_sq   = (op == OP_SQUASH);

  logic                  lf_rd_valid;
  logic [SEQ_W-1:0]      lf_rd_seq;
  logic [LFST_DEPTH-1:0] lf_valid_vec;

  ssp_id_table #(.DEPTH(SSIT_DEPTH), .IX_W(IX_W), .ID_W(ID_W)) u_ids (
    .clk(clk), .rst_n(rst_n), .clr(tbl_clr),
    .rd_st_ix(st_ix), .rd_ld_ix(ld_ix), .rd_lk_ix(lk_ix),
    .st_hit(st_hit), .st_id(st_ssid), .ld_hit(ld_hit), .ld_id(ld_ssid),
    .lk_hit(lk_hit), .lk_id(lk_ssid),
    .wr_st_en(wr_st_en), .wr_st_id(wr_st_id), .wr_ld_en(wr_ld_en), .wr_ld_id(wr_ld_id)
  );

  ssp_last_store #(.DEPTH(LFST_DEPTH), .ID_W(ID_W), .SEQ_W(SEQ_W)) u_last (
    .clk(clk), .rst_n(rst_n), .clr(tbl_clr),
    .wr_en(lf_wr), .wr_id(st_ssid), .wr_seq(req_seq),
    .iss_en(lf_iss), .iss_id(st_ssid), .iss_seq(req_seq),
    .sq_en(lf_sq), .sq_seq(req_seq),
    .rd_id(lk_ssid), .rd_valid(lf_rd_valid), .rd_seq(lf_rd_seq),
    .valid_vec(lf_valid_vec)
  );

  ssp_set_size #(.DEPTH(LFST_DEPTH), .ID_W(ID_W), .CNT_W(CNT_W)) u_size (
    .clk(clk), .rst_n(rst_n),
    .inc_en(inc_en), .inc_id(inc_id), .dec_en(dec_en), .dec_id(dec_id),
    .rd_a_id(st_ssid), .rd_b_id(ld_ssid), .cnt_a(cnt_st), .cnt_b(cnt_ld)
  );

  assign lk_seq = (lk_hit && lf_rd_valid) ? lf_rd_seq : '0;
endmodule

// File: rtl/ssp_checker.sv
`timescale 1ns/1ps
module ssp_checker #(
  parameter int LFST_DEPTH = 16,
  parameter int ID_W       = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [2:0]            req_op,
  input logic                  req_is_store,
  input logic                  st_hit,
  input logic [ID_W-1:0]       st_ssid,
  input logic [LFST_DEPTH-1:0] lf_valid_vec,
  input logic                  ev_new_set,
  input logic                  ev_store_joins,
  input logic                  ev_load_joins,
  input logic                  ev_store_moves,
  input logic                  ev_load_moves
);
  // R2 through R6: a violation takes exactly one training path.
  p_one_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_new_set, ev_store_joins, ev_load_joins, ev_store_moves, ev_load_moves}));

  p_fetch_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op == 3'd2 && st_hit) |=> lf_valid_vec[$past(st_ssid)]);

  p_fetch_miss_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op == 3'd2 && !st_hit) |=> $stable(lf_valid_vec));

  p_load_issue_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op == 3'd3 && !req_is_store) |=> $stable(lf_valid_vec));

  p_squash_only_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op == 3'd4) |=> ((lf_valid_vec & ~$past(lf_valid_vec)) == '0));

  p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op == 3'd5) |=> (lf_valid_vec == '0));
endmodule

bind store_set_predictor ssp_checker #(.LFST_DEPTH(LFST_DEPTH), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_is_store(req_is_store),
  .st_hit(st_hit), .st_ssid(st_ssid), .lf_valid_vec(lf_valid_vec),
  .ev_new_set(ev_new_set), .ev_store_joins(ev_store_joins), .ev_load_joins(ev_load_joins),
  .ev_store_moves(ev_store_moves), .ev_load_moves(ev_load_moves)
);

// File: tb/tb_store_set_predictor.sv
`timescale 1ns/1ps
module tb_store_set_predictor;
  localparam int PC_W = 32;
  localparam int SEQ_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic [PC_W-1:0] req_pc = '0, req_load_pc = '0, lk_pc = '0;
  logic [SEQ_W-1:0] req_seq = '0;
  logic req_is_store = 1'b0;
  logic [SEQ_W-1:0] lk_seq;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  store_set_predictor dut (
    .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_pc(req_pc),
    .req_load_pc(req_load_pc), .req_seq(req_seq), .req_is_store(req_is_store),
    .lk_pc(lk_pc), .lk_seq(lk_seq)
  );

  // op, store word, load word, seq, is_store, raw lookup PC, expected, requirement
  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  sw;
    logic [7:0]  lw;
    logic [15:0] seq;
    logic        st;
    logic [15:0] lk;
    logic [15:0] exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'd0,  8'd0, 16'd0,  1'b0, 16'd4,   16'd0,  4'd1 },  // R1 untrained slot
    '{3'd1, 8'd2,  8'd1, 16'd0,  1'b0, 16'd4,   16'd0,  4'd11},  // R11 set made, no store yet
    '{3'd2, 8'd2,  8'd0, 16'd10, 1'b0, 16'd4,   16'd10, 4'd2 },  // R2 both in set 1
    '{3'd2, 8'd5,  8'd0, 16'd11, 1'b0, 16'd4,   16'd10, 4'd7 },  // R7 untrained fetch ignored
    '{3'd1, 8'd3,  8'd1, 16'd0,  1'b0, 16'd4,   16'd10, 4'd3 },  // R3 store joins load set
    '{3'd2, 8'd3,  8'd0, 16'd12, 1'b0, 16'd4,   16'd12, 4'd3 },  // R3
    '{3'd0, 8'd0,  8'd0, 16'd0,  1'b0, 16'd260, 16'd12, 4'd1 },  // R1 alias by slot wrap
    '{3'd0, 8'd0,  8'd0, 16'd0,  1'b0, 16'd7,   16'd12, 4'd1 },  // R1 low bits dropped
    '{3'd3, 8'd2,  8'd0, 16'd10, 1'b1, 16'd4,   16'd12, 4'd8 },  // R8 seq mismatch
    '{3'd3, 8'd3,  8'd0, 16'd12, 1'b0, 16'd4,   16'd12, 4'd8 },  // R8 non-store ignored
    '{3'd3, 8'd3,  8'd0, 16'd12, 1'b1, 16'd4,   16'd0,  4'd8 },  // R8 match clears
    '{3'd1, 8'd2,  8'd4, 16'd0,  1'b0, 16'd16,  16'd0,  4'd4 },  // R4 load joins
    '{3'd2, 8'd2,  8'd0, 16'd20, 1'b0, 16'd16,  16'd20, 4'd4 },  // R4
    '{3'd1, 8'd6,  8'd7, 16'd0,  1'b0, 16'd28,  16'd0,  4'd2 },  // R2 set 7
    '{3'd2, 8'd6,  8'd0, 16'd30, 1'b0, 16'd28,  16'd30, 4'd2 },  // R2
    '{3'd1, 8'd6,  8'd4, 16'd0,  1'b0, 16'd28,  16'd30, 4'd5 },  // R5 2 > 1, store moves
    '{3'd2, 8'd6,  8'd0, 16'd40, 1'b0, 16'd16,  16'd40, 4'd5 },  // R5
    '{3'd0, 8'd0,  8'd0, 16'd0,  1'b0, 16'd28,  16'd30, 4'd5 },  // R5 set 7 untouched
    '{3'd1, 8'd8,  8'd9, 16'd0,  1'b0, 16'd36,  16'd0,  4'd2 },  // R2 set 9
    '{3'd1, 8'd10, 8'd11,16'd0,  1'b0, 16'd44,  16'd0,  4'd2 },  // R2 set 11
    '{3'd1, 8'd8,  8'd11,16'd0,  1'b0, 16'd44,  16'd0,  4'd6 },  // R6 tie: load moves
    '{3'd2, 8'd8,  8'd0, 16'd50, 1'b0, 16'd36,  16'd50, 4'd6 },  // R6 store stayed in 9
    '{3'd1, 8'd10, 8'd9, 16'd0,  1'b0, 16'd36,  16'd50, 4'd5 },  // R5 2 > 0 (sat dec)
    '{3'd2, 8'd10, 8'd0, 16'd60, 1'b0, 16'd36,  16'd60, 4'd5 },  // R5
    '{3'd0, 8'd0,  8'd0, 16'd0,  1'b0, 16'd44,  16'd60, 4'd6 },  // R6 moved load in 9
    '{3'd4, 8'd0,  8'd0, 16'd45, 1'b0, 16'd16,  16'd0,  4'd9 },  // R9 40 < 45
    '{3'd0, 8'd0,  8'd0, 16'd0,  1'b0, 16'd28,  16'd0,  4'd9 },  // R9 30 < 45
    '{3'd0, 8'd0,  8'd0, 16'd0,  1'b0, 16'd36,  16'd60, 4'd9 },  // R9 60 kept
    '{3'd5, 8'd0,  8'd0, 16'd0,  1'b0, 16'd36,  16'd0,  4'd10},  // R10 clear
    '{3'd2, 8'd10, 8'd0, 16'd70, 1'b0, 16'd36,  16'd0,  4'd10},  // R10 slots forgotten
    '{3'd1, 8'd12, 8'd9, 16'd0,  1'b0, 16'd36,  16'd0,  4'd2 },  // R2 retrain after clear
    '{3'd2, 8'd12, 8'd0, 16'd80, 1'b0, 16'd36,  16'd80, 4'd11},  // R11
    '{3'd4, 8'd0,  8'd0, 16'd80, 1'b0, 16'd36,  16'd80, 4'd9 },  // R9 equal survives
    '{3'd4, 8'd0,  8'd0, 16'd81, 1'b0, 16'd36,  16'd0,  4'd9 }   // R9
  };

  task automatic check(input int rq, input logic [SEQ_W-1:0] got, input logic [SEQ_W-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d: lk_seq=%0d expected %0d (lk_pc=%0h)", rq, got, exp, lk_pc);
    end
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: run hung, actual=running expected=done (all R)");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // Reset state: nothing trained (R10, R1)
    repeat (3) @(negedge clk);
    lk_pc = 32'h4;
    #1 check(10, lk_seq, 16'd0);
    lk_pc = 32'h24;
    #1 check(1, lk_seq, 16'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req_op       = VECS[i].op;
      req_pc       = 32'(VECS[i].sw) << 2;
      req_load_pc  = 32'(VECS[i].lw) << 2;
      req_seq      = VECS[i].seq;
      req_is_store = VECS[i].st;
      lk_pc        = 32'(VECS[i].lk);
      @(negedge clk);
      req_op = 3'd0;
      check(int'(VECS[i].rq), lk_seq, VECS[i].exp);
    end

    // Directed: reset in mid-run forgets the trained set 9 (R10)
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    lk_pc = 32'd36;
    #1 check(10, lk_seq, 16'd0);
    rst_n = 1'b1;

    // Directed: lookup is combinational once trained (R11)
    @(negedge clk);
    req_op = 3'd1; req_pc = 32'd80; req_load_pc = 32'd84;   // store w20, load w21 -> set 5
    @(negedge clk);
    req_op = 3'd2; req_pc = 32'd80; req_seq = 16'd99;
    @(negedge clk);
    req_op = 3'd0;
    lk_pc = 32'd84;
    #1 check(11, lk_seq, 16'd99);
    lk_pc = 32'd88;
    #1 check(1, lk_seq, 16'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule